// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block sits between a processor core and a 32-bit data memory that is addressed in words and written by byte lanes. For each access the core presents a base register value, a signed 12-bit displacement, a width/sign code and, for stores, the source register. The unit adds the displacement to the base to form the byte address. For a store, it copies the low byte, halfword or whole word of the source into the lanes the address selects and raises the matching byte-enables. For a load, it issues a read, keeps the lane and code for one cycle, and then cuts the addressed byte or halfword out of the returned word. It widens that value to 32 bits with either sign copies or zeros.

Accesses whose address does not suit their width are flagged and are not sent to memory. The memory is little-endian and returns read data one cycle after the read request.

Top module: `lsu_align`

## Requirements
- R1: `mem_addr` equals `req_base` plus `req_offset` read as a two's-complement 12-bit number (-2048..+2047), wrapping modulo 2^32. It holds for every code.
- R2: A byte store (`req_store`=1, code 000) drives `mem_we`=1 and `mem_be` = 4'b0001 shifted left by `mem_addr[1:0]`. `mem_wdata` carries `req_wsrc[7:0]` in all four lanes. Bit 0 of `mem_be` is the byte at the lowest address.
- R3: A halfword store (code 001) at an even address drives `mem_be` = 4'b0011 shifted left by `mem_addr[1:0]`. `mem_wdata` carries `req_wsrc[15:0]` in both halves.
- R4: A word store (code 010) at an address that is a multiple of 4 drives `mem_be`=4'b1111 and `mem_wdata`=`req_wsrc`.
- R5: A halfword access at an odd address, or a word access at an address that is not a multiple of 4, raises `misaligned`. In that case `mem_we`, `mem_re` and `mem_be` stay at zero, and no `load_valid` follows. Byte accesses are never misaligned.
- R6: An accepted load (`req_store`=0) drives `mem_re`=1 with `mem_be`=0. In the next cycle it drives `load_valid`=1, and `load_data` is formed from `mem_rdata` in that cycle. `load_valid` is 1 in no other cycle.
- R7: Load codes 000 (byte) and 001 (halfword) take lane `mem_addr[1:0]` (byte) or half `mem_addr[1]` (halfword). They copy the value's top bit into all upper result bits.
- R8: Load codes 100 (byte) and 101 (halfword) extract the same lanes and fill the upper result bits with zeros.
- R9: Load code 010 returns `mem_rdata` unchanged.
- R10: Unused codes (loads 011, 110, 111; stores 011 and 1xx) and cycles with `req_valid`=0 produce no read, no write, zero `mem_be` and no `misaligned`.
- R11: While `rst_n` is low and after its release, `load_valid` is 0 until a load is accepted. `load_data` is zero whenever `load_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_funct3 | input | 3 | Width/sign code |
| req_base | input | 32 | Base register value |
| req_offset | input | 12 | Signed displacement |
| req_wsrc | input | 32 | Store source register |
| mem_addr | output | 32 | Effective byte address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_wdata | output | 32 | Lane-steered write data |
| misaligned | output | 1 | Address unsuitable for width |
| mem_rdata | input | 32 | Read word, one cycle after `mem_re` |
| load_valid | output | 1 | Load result present |
| load_data | output | 32 | Extended load result |

## Verification
The sweep crosses every code, both directions, all four address lanes and displacements at both ends of the signed range. It includes a base near the top of the address space, where the sum wraps. A design that zero-extended the displacement would miss every negative offset, and a shift that used only address bit 1 for bytes would enable the wrong lane on odd addresses. Read words place set and clear sign bits in different lanes, so a result taken from the wrong lane or extended the wrong way shows up in the upper bits. Misaligned and illegal codes are checked for silence on both strobes and on the next cycle's `load_valid`, which catches a design that lets a suppressed read through.

// File: rtl/lsu_align.sv
module lsu_align #(
  parameter int OFF_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_store,
  input  logic [2:0]  req_funct3,
  input  logic [31:0] req_base,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [31:0] req_wsrc,
  output logic [31:0] mem_addr,
  output logic        mem_we,
  output logic        mem_re,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  output logic        misaligned,
  input  logic [31:0] mem_rdata,
  output logic        load_valid,
  output logic [31:0] load_data
);
  localparam int EXT_W = 32 - OFF_W;

  logic [1:0] lane;
  logic [1:0] sz;
  logic       legal, bad_align, go;

  assign mem_addr = req_base + {{EXT_W{req_offset[OFF_W-1]}}, req_offset};
  assign lane     = mem_addr[1:0];
  assign sz       = req_funct3[1:0];

  assign legal = req_store ? (!req_funct3[2] && sz != 2'd3)
                           : (sz != 2'd3 && !(req_funct3[2] && sz[1]));
  assign bad_align = legal && ((sz == 2'd1 && lane[0]) || (sz == 2'd2 && lane != 2'd0));
  assign go        = req_valid && legal && !bad_align;

  assign misaligned = req_valid && bad_align;
  assign mem_we     = go && req_store;
  assign mem_re     = go && !req_store;

  always_comb begin
    mem_be    = 4'b0000;
    mem_wdata = req_wsrc;
    case (sz)
      2'd0: begin
        mem_wdata = {4{req_wsrc[7:0]}};
        if (mem_we) mem_be = 4'b0001 << lane;
      end
      2'd1: begin
        mem_wdata = {2{req_wsrc[15:0]}};
        if (mem_we) mem_be = 4'b0011 << lane;
      end
      default: begin
        if (mem_we) mem_be = 4'b1111;
      end
    endcase
  end

  logic [2:0] pend_f3;
  logic [1:0] pend_lane;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_valid <= 1'b0;
      pend_f3    <= 3'd0;
      pend_lane  <= 2'd0;
    end else begin
      load_valid <= mem_re;
      if (mem_re) begin
        pend_f3   <= req_funct3;
        pend_lane <= lane;
      end
    end
  end

  logic [7:0]  rd_byte;
  logic [15:0] rd_half;

  assign rd_byte = 8'(mem_rdata >> {pend_lane, 3'b000});
  assign rd_half = pend_lane[1] ? mem_rdata[31:16] : mem_rdata[15:0];

  always_comb begin
    load_data = 32'd0;
    if (load_valid) begin
      case (pend_f3)
        3'b000:  load_data = {{24{rd_byte[7]}}, rd_byte};
        3'b001:  load_data = {{16{rd_half[15]}}, rd_half};
        3'b100:  load_data = {24'd0, rd_byte};
        3'b101:  load_data = {16'd0, rd_half};
        default: load_data = mem_rdata;
      endcase
    end
  end

  AST_MISALIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (mem_be == 4'b0000 && !mem_we && !mem_re)); // R5
  AST_BE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4)); // R2
  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> load_valid); // R6
  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> $past(mem_re)); // R6
  AST_SIGNED_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && req_funct3 == 3'b000) |=> (load_data[31:8] == {24{load_data[7]}})); // R7
  AST_UNSIGNED_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && req_funct3 == 3'b100) |=> (load_data[31:8] == 24'd0)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R10
endmodule

// File: tb/lsu_align_test.sv
module lsu_align_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [2:0]  req_funct3 = 3'd0;
  logic [31:0] req_base = 32'd0;
  logic [11:0] req_offset = 12'd0;
  logic [31:0] req_wsrc = 32'd0;
  logic [31:0] mem_rdata = 32'd0;
  logic [31:0] mem_addr, mem_wdata, load_data;
  logic        mem_we, mem_re, misaligned, load_valid;
  logic [3:0]  mem_be;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  lsu_align uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_funct3(req_funct3), .req_base(req_base), .req_offset(req_offset),
    .req_wsrc(req_wsrc), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .misaligned(misaligned),
    .mem_rdata(mem_rdata), .load_valid(load_valid), .load_data(load_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic access(input logic st, input logic [2:0] f3, input logic [31:0] base,
                        input logic [11:0] off, input logic [31:0] src, input logic [31:0] rd);
    logic [31:0] ea, ebe, ewd, eld;
    int nbytes, ln;
    logic legal, mis, go;
    longint val;
    ea = base + 32'($signed(off));
    ln = int'(ea % 4);
    nbytes = 1 << f3[1:0];
    if (st) legal = (f3 == 3'b000 || f3 == 3'b001 || f3 == 3'b010);
    else    legal = (f3 == 3'b000 || f3 == 3'b001 || f3 == 3'b010 || f3 == 3'b100 || f3 == 3'b101);
    mis = legal && (ln % nbytes != 0);
    go = legal && !mis;
    ebe = 0; ewd = 0;
    for (int i = 0; i < 4; i++) begin
      if (st && go && i >= ln && i < ln + nbytes) ebe[i] = 1'b1;
      ewd[8*i +: 8] = src[8*(i % nbytes) +: 8];
    end
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_funct3 = f3;
    req_base = base; req_offset = off; req_wsrc = src;
    #2;
    chk("R1 mem_addr", mem_addr, ea);
    chk("R5 misaligned", 32'(misaligned), 32'(mis));
    chk("R10 mem_we", 32'(mem_we), 32'(st && go));
    chk("R6 mem_re", 32'(mem_re), 32'(!st && go));
    if (!st && go) chk("R6 mem_be on load", 32'(mem_be), 32'd0);
    else if (nbytes == 1) chk("R2 mem_be", 32'(mem_be), ebe);
    else if (nbytes == 2) chk("R3 mem_be", 32'(mem_be), ebe);
    else chk("R4 mem_be", 32'(mem_be), ebe);
    if (st && go) begin
      if (nbytes == 1) chk("R2 mem_wdata", mem_wdata, ewd);
      else if (nbytes == 2) chk("R3 mem_wdata", mem_wdata, ewd);
      else chk("R4 mem_wdata", mem_wdata, ewd);
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    mem_rdata = rd;
    #2;
    chk("R6 load_valid", 32'(load_valid), 32'(!st && go));
    if (!st && go) begin
      val = longint'((rd >> (8 * ln)) & ((nbytes == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nbytes)) - 1)));
      if (!f3[2] && nbytes < 4 && val >= (longint'(1) << (8 * nbytes - 1)))
        val = val - (longint'(1) << (8 * nbytes));
      eld = 32'(val);
      if (f3 == 3'b010) chk("R9 load_data", load_data, eld);
      else if (f3[2]) chk("R8 load_data", load_data, eld);
      else chk("R7 load_data", load_data, eld);
    end else begin
      chk("R11 load_data idle", load_data, 32'd0);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [11:0] offs [5];
    logic [31:0] bases [3];
    logic [31:0] rds [3];
    offs[0] = 12'h000; offs[1] = 12'h7FF; offs[2] = 12'h800; offs[3] = 12'hFFF; offs[4] = 12'h005;
    bases[0] = 32'h1000_0000; bases[1] = 32'hFFFF_FFFC; bases[2] = 32'h0000_0400;
    rds[0] = 32'h80FF_7F01; rds[1] = 32'h7F80_01FE; rds[2] = 32'hC35A_8A96;

    repeat (3) @(posedge clk);
    #1;
    chk("R11 load_valid in reset", 32'(load_valid), 32'd0);
    chk("R11 load_data in reset", load_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 load_valid after reset", 32'(load_valid), 32'd0);

    req_store = 1'b1; req_funct3 = 3'b010; req_base = 32'h100; req_offset = 12'h0;
    #1;
    chk("R10 idle mem_we", 32'(mem_we), 32'd0);
    chk("R10 idle mem_be", 32'(mem_be), 32'd0);
    req_store = 1'b0;
    #1;
    chk("R10 idle mem_re", 32'(mem_re), 32'd0);

    for (int b = 0; b < 3; b++)
      for (int lo = 0; lo < 4; lo++)
        for (int o = 0; o < 5; o++)
          for (int f = 0; f < 8; f++)
            for (int s = 0; s < 2; s++)
              access(s[0], f[2:0], bases[b] + 32'(lo), offs[o],
                     32'hA5C3_96E1 ^ (32'(o) << 4) ^ 32'(f), rds[(b + lo + o) % 3]);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule